// File: doc/BRIEF.md
# Shared-Timebase Multi-Channel PWM Generator

This block drives several pulse-width-modulated outputs from one common timebase. An 8-bit prescaler divides the input clock into a local tick. A shared 8-bit counter advances once per tick and wraps after 256 ticks, so every PWM period is exactly 256 local cycles long. Only the prescaler changes the period length. Each channel compares the shared count against its own duty value. The channel output is high from count 0 up to and including that value, and low for the rest of the period.

Software programs the block through a simple write port (valid, address, data), synchronous to the input clock. A control word holds the prescaler, split into two nibbles that are not adjacent, and one enable bit shared by all channels. Each channel also has a duty register. Values written while the generator runs are held in shadow registers and are copied to the active set at the next period boundary, so no period is ever cut short or stretched. While the enable bit is clear, all outputs are low and the timebase is held at its start point.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low and the generator is disabled.
- R2: The control word is at address 0x50 and its bit 9 is the shared enable. While the enable is 0, all outputs are low. After a write that sets the enable, the first clock cycle is count 0 of a new period.
- R3: The prescaler value P is taken from control bits 3:0 (low nibble) and bits 14:11 (high nibble). Each count value lasts P+1 input clock cycles.
- R4: The shared count runs from 0 to 255 and then wraps to 0, so one period is 256*(P+1) input clocks.
- R5: Channel k's duty register is at address 4*k, using data bits 7:0. With duty value V, the output is high for counts 0 to V (V+1 local cycles) and low for the other counts.
- R6: A duty value of 255 keeps the output high for the whole period, with no low cycle.
- R7: Duty or prescaler writes made while the generator runs take effect only at the next period boundary. Writes made while it is disabled take effect when it is next enabled.
- R8: Writes to any address other than the control word and the duty registers have no effect on the outputs.
- R9: Writing one channel's duty register leaves the waveform of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The four channels are loaded with duty values at the extremes: 0 (a single high count), 255 (never low), and a value just below 255. These separate off-by-one errors in the compare from errors in the wrap. A prescaler with both nibbles non-zero shows whether the split fields are assembled in the right order. A prescaler of 0 shows the undivided case. A run that rewrites one duty and the prescaler in mid-period tells boundary-synchronized loading apart from immediate loading, and shows that the other channels are untouched. Random prescaler and duty sets, a write to an unmapped address, and duty writes while disabled cover the rest.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PWM_CNT_W    = 8;
  localparam int PWM_PS_W     = 8;
  localparam int PWM_ADDR_W   = 8;
  localparam int PWM_DATA_W   = 16;
  localparam int PWM_NUM_CH   = 4;
  // register map
  localparam int CTRL_ADDR    = 'h50;
  localparam int DUTY_BASE    = 'h00;
  localparam int DUTY_STRIDE  = 4;
  // control word fields
  localparam int EN_BIT       = 9;
  localparam int PS_LO_LSB    = 0;
  localparam int PS_HI_LSB    = 11;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_NUM_CH,
  parameter int CNT_W  = PWM_CNT_W,
  parameter int PS_W   = PWM_PS_W,
  parameter int ADDR_W = PWM_ADDR_W,
  parameter int DATA_W = PWM_DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         wrap,
  output logic                         en_q,
  output logic [PS_W-1:0]              ps_act,
  output logic [NUM_CH-1:0][CNT_W-1:0] duty_act
);
  localparam int HALF = PS_W / 2;

  logic                         ctrl_hit;
  logic                         en_d;
  logic                         load;
  logic [PS_W-1:0]              ps_sh_q, ps_sh_d;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_sh_q, duty_sh_d;
  logic                         data_unused;

  assign data_unused = ^wr_data;
  assign ctrl_hit    = wr_valid && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    en_d    = en_q;
    ps_sh_d = ps_sh_q;
    if (ctrl_hit) begin
      en_d    = wr_data[EN_BIT];
      ps_sh_d = {wr_data[PS_HI_LSB +: HALF], wr_data[PS_LO_LSB +: HALF]};
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
    logic hit;
    assign hit = wr_valid && (wr_addr == ADDR_W'(DUTY_BASE + g * DUTY_STRIDE));
    always_comb duty_sh_d[g] = hit ? wr_data[CNT_W-1:0] : duty_sh_q[g];
  end

  // copy shadow to active while idle or at the end of a period
  assign load = !en_q || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      ps_sh_q   <= '0;
      duty_sh_q <= '0;
    end else begin
      en_q      <= en_d;
      ps_sh_q   <= ps_sh_d;
      duty_sh_q <= duty_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_act   <= '0;
      duty_act <= '0;
    end else if (load) begin
      ps_act   <= ps_sh_d;
      duty_act <= duty_sh_d;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W = PWM_CNT_W,
  parameter int PS_W  = PWM_PS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PS_W-1:0]  ps_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick,
  output logic             wrap
);
  logic [PS_W-1:0]  pre_q, pre_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign tick   = en && (pre_q == ps_act);
  assign wrap   = tick && (cnt_q == {CNT_W{1'b1}});
  assign cnt_ce = tick || !en;

  always_comb begin
    if (!en)       pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
    cnt_d = en ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp
  import pwm_pkg::*;
#(
  parameter int CNT_W = PWM_CNT_W
) (
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             out
);
  assign out = en && (cnt <= duty);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_NUM_CH,
  parameter int CNT_W  = PWM_CNT_W,
  parameter int PS_W   = PWM_PS_W,
  parameter int ADDR_W = PWM_ADDR_W,
  parameter int DATA_W = PWM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                         en_q;
  logic                         tick;
  logic                         wrap;
  logic [CNT_W-1:0]             cnt_q;
  logic [PS_W-1:0]              ps_act;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_act;

  pwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wrap(wrap), .en_q(en_q), .ps_act(ps_act),
    .duty_act(duty_act)
  );

  pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .en(en_q), .ps_act(ps_act),
    .cnt_q(cnt_q), .tick(tick), .wrap(wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_cmp #(.CNT_W(CNT_W)) u_cmp (
      .en(en_q), .cnt(cnt_q), .duty(duty_act[g]), .out(pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = PWM_NUM_CH,
  parameter int CNT_W  = PWM_CNT_W,
  parameter int PS_W   = PWM_PS_W,
  parameter int ADDR_W = PWM_ADDR_W,
  parameter int DATA_W = PWM_DATA_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_valid,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic [DATA_W-1:0]            wr_data,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic                         en_q,
  input logic                         tick,
  input logic                         wrap,
  input logic [CNT_W-1:0]             cnt_q,
  input logic [PS_W-1:0]              ps_act,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty_act
);
  logic dis_wr;
  assign dis_wr = wr_valid && (wr_addr == ADDR_W'(CTRL_ADDR)) && !wr_data[EN_BIT];

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pwm_out == '0));

  p_disable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (pwm_out == '0));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (cnt_q == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tick) |=> $stable(cnt_q));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wrap) |=> ($stable(duty_act) && $stable(ps_act)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_full
    p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && (duty_act[g] == {CNT_W{1'b1}})) |-> pwm_out[g]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .pwm_out(pwm_out), .en_q(en_q), .tick(tick),
  .wrap(wrap), .cnt_q(cnt_q), .ps_act(ps_act), .duty_act(duty_act)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_err = 0;
  int ps0, ps1;
  int d0 [NCH];
  int d1 [NCH];

  always #2.5 clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  function automatic logic [15:0] ctrl_word(int ps, bit en);
    return 16'((ps & 15) | (int'(en) << 9) | (((ps >> 4) & 15) << 11));
  endfunction

  function automatic bit exp_bit(int n, int p0, int v0, int p1, int v1);
    int len0;
    int pos;
    len0 = 256 * (p0 + 1);
    if (n < len0) begin
      pos = n / (p0 + 1);
      return pos <= v0;
    end
    pos = ((n - len0) / (p1 + 1)) % 256;
    return pos <= v1;
  endfunction

  task automatic check(bit got, bit exp, string req, int ch, int n);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s ch%0d n=%0d actual=%0b expected=%0b", req, ch, n, got, exp);
    end
  endtask

  task automatic check_low(string req);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check(pwm_out[c], 1'b0, req, c, -1);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  // disable, load duties while idle, then enable with prescaler ps
  task automatic start(int ps, int du [NCH]);
    wr(8'h50, ctrl_word(0, 1'b0));
    check_low("R2 disable");
    for (int c = 0; c < NCH; c++) begin
      wr(8'(4 * c), 16'(du[c]));
      d0[c] = du[c];
      d1[c] = du[c];
    end
    check_low("R2 duty write while idle");
    ps0 = ps;
    ps1 = ps;
    wr(8'h50, ctrl_word(ps, 1'b1));
  endtask

  task automatic run(int cycles, string req, int wn, logic [7:0] wa, logic [15:0] wd,
                     int wn2, logic [7:0] wa2, logic [15:0] wd2);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        check(pwm_out[c], exp_bit(n, ps0, d0[c], ps1, d1[c]), req, c, n);
      if (n == wn) begin
        wr_valid = 1'b1; wr_addr = wa; wr_data = wd;
      end else if (n == wn2) begin
        wr_valid = 1'b1; wr_addr = wa2; wr_data = wd2;
      end else begin
        wr_valid = 1'b0;
      end
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int du [NCH];
    int ps;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    repeat (2) check_low("R1 reset");

    // R5 R6 R4: extreme duties, undivided clock, two periods
    du = '{0, 127, 254, 255};
    start(0, du);
    run(600, "R5 R6 R4 ps=0", -1, 8'h0, 16'h0, -1, 8'h0, 16'h0);

    // R3: both prescaler nibbles non-zero (0x12 = 18)
    du = '{10, 200, 255, 0};
    start(8'h12, du);
    run(256 * 19 + 60, "R3 split prescaler", -1, 8'h0, 16'h0, -1, 8'h0, 16'h0);

    // R7 R9: mid-period duty and prescaler change
    du = '{50, 60, 70, 80};
    start(1, du);
    d1[1] = 200;
    ps1 = 3;
    run(512 + 1024 + 40, "R7 R9 boundary update", 100, 8'h04, 16'd200,
        200, 8'h50, ctrl_word(3, 1'b1));

    // R8: unmapped writes change nothing
    du = '{30, 90, 150, 255};
    start(2, du);
    run(768 + 300, "R8 unmapped write", 120, 8'h10, 16'h00FF,
        400, 8'h51, 16'h0000);

    // R2: disabling mid-run drives all outputs low
    wr(8'h50, ctrl_word(2, 1'b0));
    repeat (4) check_low("R2 mid-run disable");

    // random sets
    for (int it = 0; it < 6; it++) begin
      ps = int'($urandom_range(0, 5));
      for (int c = 0; c < NCH; c++) du[c] = int'($urandom_range(0, 255));
      start(ps, du);
      run(320 * (ps + 1), "R5 random", -1, 8'h0, 16'h0, -1, 8'h0, 16'h0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule